// File: doc/BRIEF.md
# Link Deadlock Pattern Checker and Fault Classifier

This block is a clocked observer for one protected segment of a handshake-driven link. It takes three kinds of sampled inputs. The first is one completion-detect bit per parallel word lane of the first stage after the suspected fault. The second is the acknowledge levels along a chain of pipeline stages, together with the acknowledge of that post-fault stage. The third is an external flag that reports any transition activity. All of these arrive from another timing domain, so each is passed through a two-flop synchronizer before use.

On each evaluation strobe the block decides whether the link looks deadlocked. Two conditions must hold. No activity may have been seen since the previous evaluation, and the acknowledge chain must show a run of alternating values at the upstream end followed by a run of identical values that reaches the downstream end. When both hold, a majority vote over the completion-detect lanes says whether the stuck word is nearly full or nearly empty. That result is combined with the post-fault acknowledge level to name the fault as transient or permanent. The registered 1-of-2 code and a match flag feed a separate detector state machine, which decides on recovery.

Top module: `dlk_classifier`

## Requirements
- R1: Every input except `eval_strobe` is resynchronized by two flops, so an evaluation at clock edge k uses the input values sampled at edge k-2.
- R2: While `rst` is high, and on the first cycle after it, `fault_code` is 2'b00 and `pattern_ok` is 0.
- R3: Both outputs change only on a clock edge at which `eval_strobe` is high. In every other cycle they hold their value, whatever the inputs do.
- R4: The word is judged nearly full when at least two completion-detect bits are 1. With one zero lane, `post_ack`=1 gives 2'b01 and `post_ack`=0 gives 2'b10.
- R5: The word is judged nearly empty when at least two completion-detect bits are 0. For example, `cd_bits`=8'b00010000 counts as nearly empty and not nearly full.
- R6: Fault code bit 1 = (full AND NOT ack) OR (empty AND ack). Bit 0 = (full AND ack) OR (empty AND NOT ack). Here 2'b01 means transient and 2'b10 means permanent.
- R7: `ack_chain[0]` is the most upstream stage. The pattern matches only if every adjacent pair that differs lies upstream of every adjacent pair that is equal, and the last pair is equal. A fully uniform chain matches. A fully alternating chain does not.
- R8: If the synchronized `activity` was high, or any synchronized data input (`cd_bits`, `ack_chain`, `post_ack`) changed, since the previous evaluation, the next evaluation yields 2'b00.
- R9: Code 2'b11 is never driven. When both the nearly-full and nearly-empty judgments hold, the code is 2'b00.
- R10: `pattern_ok` is 1 exactly when the registered `fault_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_strobe | input | 1 | Evaluation request, already in the clock domain |
| cd_bits | input | N_WORDS | Completion-detect level per word lane of the post-fault stage |
| ack_chain | input | N_STAGES | Acknowledge levels along the stage chain; bit 0 is upstream |
| post_ack | input | 1 | Acknowledge level of the post-fault stage |
| activity | input | 1 | High when transitions were observed on the link |
| fault_code | output | 2 | 00 none, 01 transient, 10 permanent |
| pattern_ok | output | 1 | Deadlock pattern matched and classified |

## Verification
The assertions assume the stuck link has at most one completion-detect lane that disagrees with the others, which is the single-bit-fault premise. Under that premise the minority check on the vote is valid. The stimulus respects this in its deadlock cases. It departs from it only in one deliberate case, where an even split makes both judgments true, to confirm that the code falls back to zero. Inputs are held for several cycles before each pair of strobes, so that the resynchronized values settle and the change tracker is clear. Two cases place a strobe one cycle after a change, or change values between strobes, to exercise the synchronizer delay and the change rule.

// File: rtl/dlk_pkg.sv
package dlk_pkg;

  typedef enum logic [1:0] {
    FC_NONE      = 2'b00,
    FC_TRANSIENT = 2'b01,
    FC_PERMANENT = 2'b10
  } fault_code_e;

endpackage

// File: rtl/dlk_sync.sv
module dlk_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= din;
      q      <= meta_q;
    end
  end

  // R1: two-cycle latency once out of reset
  a_r1_two_flop: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2)) |-> (q == $past(din, 2)));

endmodule

// File: rtl/dlk_cd_vote.sv
module dlk_cd_vote #(
  parameter int N_WORDS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_WORDS-1:0] cd,
  output logic               near_full,
  output logic               near_empty
);

  localparam int CNT_W = $clog2(N_WORDS + 1);

  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W-1:0] zeros_cnt;

  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      ones_cnt = ones_cnt + CNT_W'(cd[i]);
    end
    zeros_cnt  = CNT_W'(N_WORDS) - ones_cnt;
    near_full  = (ones_cnt  >= CNT_W'(2));
    near_empty = (zeros_cnt >= CNT_W'(2));
  end

  // R5: a single raised lane reads as nearly empty
  a_r5_lone_one: assert property (@(posedge clk) disable iff (rst)
    ($countones(cd) == 1) |-> (near_empty && !near_full));

  // R4: a single dropped lane reads as nearly full
  a_r4_lone_zero: assert property (@(posedge clk) disable iff (rst)
    ($countones(~cd) == 1) |-> (near_full && !near_empty));

endmodule

// File: rtl/dlk_ack_pattern.sv
module dlk_ack_pattern #(
  parameter int N_STAGES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_STAGES-1:0] acks,
  output logic                match
);

  localparam int N_PAIRS = N_STAGES - 1;

  logic [N_PAIRS-1:0] differs;
  logic [N_PAIRS-1:0] order_bad;

  genvar g;
  generate
    for (g = 0; g < N_PAIRS; g++) begin : g_pair
      assign differs[g] = acks[g] ^ acks[g+1];
    end
    for (g = 0; g < N_PAIRS; g++) begin : g_order
      if (g == N_PAIRS - 1) begin : g_last
        assign order_bad[g] = 1'b0;
      end else begin : g_mid
        assign order_bad[g] = ~differs[g] & differs[g+1];
      end
    end
  endgenerate

  assign match = ~(|order_bad) & ~differs[N_PAIRS-1];

  // R7: uniform chain always matches
  a_r7_uniform: assert property (@(posedge clk) disable iff (rst)
    ((acks == '0) || (acks == '1)) |-> match);

endmodule

// File: rtl/dlk_activity.sv
module dlk_activity #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] snap,
  input  logic              act,
  input  logic              strobe,
  output logic              trans_seen
);

  logic [DATA_W-1:0] prev_q;
  logic              sticky_q;
  logic              change_now;

  assign change_now = act | (snap != prev_q);
  assign trans_seen = sticky_q | change_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= snap;
      sticky_q <= strobe ? 1'b0 : (sticky_q | change_now);
    end
  end

  // R8: activity between strobes is remembered
  a_r8_act_held: assert property (@(posedge clk) disable iff (rst)
    (act && !strobe) |=> trans_seen);

endmodule

// File: rtl/dlk_classifier.sv
module dlk_classifier
  import dlk_pkg::*;
#(
  parameter int N_WORDS  = 8,
  parameter int N_STAGES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                eval_strobe,
  input  logic [N_WORDS-1:0]  cd_bits,
  input  logic [N_STAGES-1:0] ack_chain,
  input  logic                post_ack,
  input  logic                activity,
  output logic [1:0]          fault_code,
  output logic                pattern_ok
);

  localparam int DATA_W = N_WORDS + N_STAGES + 1;
  localparam int SNAP_W = DATA_W + 1;

  logic [SNAP_W-1:0]   raw_snap;
  logic [SNAP_W-1:0]   sync_snap;
  logic [N_WORDS-1:0]  cd_s;
  logic [N_STAGES-1:0] ack_s;
  logic                pack_s;
  logic                act_s;
  logic                near_full;
  logic                near_empty;
  logic                chain_match;
  logic                trans_seen;
  fault_code_e         class_code;
  fault_code_e         next_code;

  assign raw_snap = {activity, post_ack, ack_chain, cd_bits};

  dlk_sync #(.WIDTH(SNAP_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_snap),
    .q   (sync_snap)
  );

  assign cd_s   = sync_snap[N_WORDS-1:0];
  assign ack_s  = sync_snap[N_WORDS +: N_STAGES];
  assign pack_s = sync_snap[DATA_W-1];
  assign act_s  = sync_snap[SNAP_W-1];

  dlk_cd_vote #(.N_WORDS(N_WORDS)) u_vote (
    .clk        (clk),
    .rst        (rst),
    .cd         (cd_s),
    .near_full  (near_full),
    .near_empty (near_empty)
  );

  dlk_ack_pattern #(.N_STAGES(N_STAGES)) u_pattern (
    .clk   (clk),
    .rst   (rst),
    .acks  (ack_s),
    .match (chain_match)
  );

  dlk_activity #(.DATA_W(DATA_W)) u_activity (
    .clk        (clk),
    .rst        (rst),
    .snap       (sync_snap[DATA_W-1:0]),
    .act        (act_s),
    .strobe     (eval_strobe),
    .trans_seen (trans_seen)
  );

  always_comb begin
    if (near_full && near_empty) begin
      class_code = FC_NONE;
    end else if ((near_full && !pack_s) || (near_empty && pack_s)) begin
      class_code = FC_PERMANENT;
    end else if ((near_full && pack_s) || (near_empty && !pack_s)) begin
      class_code = FC_TRANSIENT;
    end else begin
      class_code = FC_NONE;
    end
    next_code = (chain_match && !trans_seen) ? class_code : FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_code <= FC_NONE;
      pattern_ok <= 1'b0;
    end else if (eval_strobe) begin
      fault_code <= next_code;
      pattern_ok <= (next_code != FC_NONE);
    end
  end

  // R9: the invalid code never appears
  a_r9_never_invalid: assert property (@(posedge clk) disable iff (rst)
    fault_code != 2'b11);

  // R3: outputs only move on a strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !eval_strobe |=> ($stable(fault_code) && $stable(pattern_ok)));

  // R8: observed activity forces the empty code
  a_r8_trans_clears: assert property (@(posedge clk) disable iff (rst)
    (eval_strobe && trans_seen) |=> (fault_code == 2'b00));

  // R7: a mismatched chain cannot produce a classification
  a_r7_no_match_no_code: assert property (@(posedge clk) disable iff (rst)
    (eval_strobe && !chain_match) |=> !pattern_ok);

endmodule

// File: tb/dlk_classifier_tb.sv
module dlk_classifier_tb;

  localparam int NW = 8;
  localparam int NS = 6;
  localparam int DW = NW + NS + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          eval_strobe = 1'b0;
  logic [NW-1:0] cd_bits = '0;
  logic [NS-1:0] ack_chain = '0;
  logic          post_ack = 1'b0;
  logic          activity = 1'b0;
  logic [1:0]    fault_code;
  logic          pattern_ok;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dlk_classifier #(.N_WORDS(NW), .N_STAGES(NS)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .eval_strobe (eval_strobe),
    .cd_bits     (cd_bits),
    .ack_chain   (ack_chain),
    .post_ack    (post_ack),
    .activity    (activity),
    .fault_code  (fault_code),
    .pattern_ok  (pattern_ok)
  );

  // behavioural reference model
  typedef struct packed {
    logic          act;
    logic          pa;
    logic [NS-1:0] ack;
    logic [NW-1:0] cd;
  } snap_t;

  snap_t      hist[$];
  snap_t      m_last;
  bit         m_seen;
  logic [1:0] m_code;

  function automatic logic [1:0] ref_class(snap_t s);
    int ones;
    bit full, empty, chain_ok, in_equal;
    ones = 0;
    for (int i = 0; i < NW; i++) if (s.cd[i]) ones++;
    full  = (ones >= 2);
    empty = ((NW - ones) >= 2);
    chain_ok = 1;
    in_equal = 0;
    for (int i = 0; i < NS - 1; i++) begin
      if (s.ack[i] == s.ack[i+1]) in_equal = 1;
      else if (in_equal) chain_ok = 0;
    end
    if (s.ack[NS-2] != s.ack[NS-1]) chain_ok = 0;
    if (!chain_ok || (full && empty)) return 2'b00;
    if (full)  return s.pa ? 2'b01 : 2'b10;
    if (empty) return s.pa ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    snap_t cur;
    bit    moved;
    if (rst) begin
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
      m_last = '0;
      m_seen = 0;
      m_code = 2'b00;
    end else begin
      cur   = hist[0];
      moved = cur.act || (cur.pa != m_last.pa) || (cur.ack != m_last.ack) || (cur.cd != m_last.cd);
      if (eval_strobe) begin
        m_code = (m_seen || moved) ? 2'b00 : ref_class(cur);
        m_seen = 0;
      end else begin
        m_seen = m_seen || moved;
      end
      m_last = cur;
      void'(hist.pop_front());
      hist.push_back(snap_t'{activity, post_ack, ack_chain, cd_bits});
    end
  end

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b at cycle %0d", req, got, exp, cycles);
    end
  endtask

  // R1 cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst && hist.size() == 2) begin
      check("R1_model_code", fault_code, m_code);
      check("R10_model_ok", {1'b0, pattern_ok}, {1'b0, m_code != 2'b00});
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic strobe_once();
    eval_strobe = 1'b1;
    @(negedge clk);
    eval_strobe = 1'b0;
  endtask

  task automatic apply(logic [NW-1:0] cd, logic [NS-1:0] ak, logic pa, logic act);
    cd_bits = cd; ack_chain = ak; post_ack = pa; activity = act;
    repeat (4) @(negedge clk);
    strobe_once();
    repeat (3) @(negedge clk);
    strobe_once();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2_reset_code", fault_code, 2'b00);
    check("R2_reset_ok", {1'b0, pattern_ok}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    check("R2_after_reset", fault_code, 2'b00);

    // R5 R6: one raised lane, ack low -> transient
    apply(8'b00010000, 6'b111101, 1'b0, 1'b0);
    check("R5_empty_transient", fault_code, 2'b01);
    check("R10_ok_high", {1'b0, pattern_ok}, 2'b01);
    // R6: same lanes, ack high -> permanent
    apply(8'b00010000, 6'b111101, 1'b1, 1'b0);
    check("R6_empty_permanent", fault_code, 2'b10);
    // R4: one dropped lane
    apply(8'b11101111, 6'b111101, 1'b1, 1'b0);
    check("R4_full_ack1", fault_code, 2'b01);
    apply(8'b11101111, 6'b111101, 1'b0, 1'b0);
    check("R4_full_ack0", fault_code, 2'b10);

    // R7: uniform chain matches, bad orderings do not
    apply(8'b00010000, 6'b000000, 1'b0, 1'b0);
    check("R7_uniform", fault_code, 2'b01);
    apply(8'b00010000, 6'b111100, 1'b0, 1'b0);
    check("R7_equal_before_diff", fault_code, 2'b00);
    check("R10_ok_low", {1'b0, pattern_ok}, 2'b00);
    apply(8'b00010000, 6'b101010, 1'b0, 1'b0);
    check("R7_all_alternate", fault_code, 2'b00);

    // R8: activity flag blocks classification
    apply(8'b00010000, 6'b111101, 1'b0, 1'b1);
    check("R8_activity", fault_code, 2'b00);
    activity = 1'b0;

    // R9: even split -> both judgments -> none
    apply(8'b11110000, 6'b111101, 1'b0, 1'b0);
    check("R9_both_judged", fault_code, 2'b00);

    // R8: data change between strobes
    apply(8'b00010000, 6'b111101, 1'b0, 1'b0);
    check("R8_setup", fault_code, 2'b01);
    ack_chain = 6'b000000;
    repeat (4) @(negedge clk);
    strobe_once();
    check("R8_changed_between", fault_code, 2'b00);
    repeat (3) @(negedge clk);
    strobe_once();
    check("R8_settled", fault_code, 2'b01);

    // R1: strobe in the same cycle as a change still sees old values
    post_ack = 1'b1;
    strobe_once();
    check("R1_sync_delay", fault_code, 2'b01);
    repeat (4) @(negedge clk);
    strobe_once();
    check("R1_change_seen", fault_code, 2'b00);
    repeat (3) @(negedge clk);
    strobe_once();
    check("R1_new_value", fault_code, 2'b10);

    // R3: no strobe, outputs hold while inputs move
    cd_bits = 8'b11110000;
    ack_chain = 6'b101010;
    activity = 1'b1;
    repeat (8) @(negedge clk);
    check("R3_hold_code", fault_code, 2'b10);
    check("R3_hold_ok", {1'b0, pattern_ok}, 2'b01);
    activity = 1'b0;

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule